// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block decides, moment by moment, which transmit queues of a port may send. It compares a free-running time value (a seconds word and a nanoseconds word) against a programmed schedule. The schedule is a list of entries, each holding a gate mask and a duration. Once the base time arrives, the block walks the list from its first entry. It advances to the next entry when the current entry's duration has run out. It goes back to entry 0 at every cycle boundary, which falls one cycle time after the previous one.

Two list banks exist. The scheduler executes one of them while the other can be rewritten through the list write port. A switch request swaps the two banks at the next cycle boundary and gives a one-cycle flag. An optional extension value pushes that switching boundary back. An offset field moves every comparison earlier, to make up for latency in the time path. Configuration words are written through a simple internal register write port.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, and while enabled but before the base time (register 0 holds nanoseconds, register 1 holds seconds), every bit of `gate_open` is 1 and `list_swapped` is 0.
- R2: When the time reaches the base time, entry 0 of the active list is applied. Bits 31:24 of an entry are the gate mask and bits 23:0 are its duration in ns. Entries 0 to length-1 run back to back, and the length is held in register 5.
- R3: After the last entry has expired, its mask stays in place until the next cycle boundary. Boundaries fall at the base time plus whole multiples of the cycle time (register 2 holds nanoseconds, register 3 holds seconds), and each boundary restarts at entry 0.
- R4: If the cycle-time nanosecond word is 1,000,000,000 or more, the excess is carried into seconds before use. For example, 2,000,000,500 ns with 0 s acts as 2 s + 500 ns.
- R5: List writes always go to the inactive (shadow) bank and do not change the gates produced by the active bank.
- R6: Writing 1 to control bit 1 (control is register 6) leaves a switch pending until the next cycle boundary. At that boundary the banks swap, the new bank starts at entry 0, `list_swapped` pulses high for one clock and the pending request clears.
- R7: While a switch is pending, the boundary that performs it is delayed by the extension value in register 4 (ns). The following boundaries are then counted from the delayed point.
- R8: Control bits 31:24 hold an offset in ns that is added to the time input before every comparison, so boundaries and entry changes happen that much earlier.
- R9: Control bit 0 enables the scheduler. Clearing it returns all gates to open within two clocks.
- R10: A list length of 0 keeps all gates open while the scheduler runs. Lengths above the list depth are clamped to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_sec | input | 32 | Current time, seconds |
| tm_ns | input | 32 | Current time, nanoseconds (below 1e9) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0..6) |
| cfg_wdata | input | 32 | Register write data |
| lst_we | input | 1 | List entry write strobe (to shadow bank) |
| lst_addr | input | AW | List entry index |
| lst_wdata | input | 32 | List entry: mask 31:24, duration 23:0 |
| gate_open | output | NQ | Per-queue gate-open vector |
| list_swapped | output | 1 | One-clock pulse when the banks swap |

## Verification
On every cycle, the assertions check the following: gates are open while idle, the entry index stays below the length, the mask holds after the list is used up, a swap flag only follows a pending request, the request clears after it is taken, and the cycle time stays normalised. The bench scenarios are the only way to show behaviour that depends on time. This covers the instant entry 0 appears at the base time, the entry durations, the restart at each cycle boundary, the delay that the extension adds to a switching boundary, the earlier timing from the offset, the seconds carry of a cycle time larger than one second, and the fact that writes to the shadow list leave the running gates untouched.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam logic [31:0] NS_PER_S = 32'd1000000000;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] ns;
  } tstamp_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} sched_st_e;

  localparam logic [2:0] A_BASE_NS = 3'd0;
  localparam logic [2:0] A_BASE_S  = 3'd1;
  localparam logic [2:0] A_CYC_NS  = 3'd2;
  localparam logic [2:0] A_CYC_S   = 3'd3;
  localparam logic [2:0] A_EXT     = 3'd4;
  localparam logic [2:0] A_LEN     = 3'd5;
  localparam logic [2:0] A_CTRL    = 3'd6;

  function automatic tstamp_t ts_from_ns(logic [31:0] ns);
    tstamp_t r;
    r.sec = 32'd0;
    r.ns  = ns;
    return r;
  endfunction

  // Both operands must already have ns below one second.
  function automatic tstamp_t ts_add(tstamp_t a, tstamp_t b);
    tstamp_t r;
    logic [32:0] s;
    s = {1'b0, a.ns} + {1'b0, b.ns};
    if (s >= {1'b0, NS_PER_S}) begin
      r.ns  = 32'(s - {1'b0, NS_PER_S});
      r.sec = a.sec + b.sec + 32'd1;
    end else begin
      r.ns  = s[31:0];
      r.sec = a.sec + b.sec;
    end
    return r;
  endfunction

  function automatic logic ts_ge(tstamp_t a, tstamp_t b);
    return {a.sec, a.ns} >= {b.sec, b.ns};
  endfunction

  // A 32-bit ns word holds at most four whole seconds.
  function automatic tstamp_t ts_norm(tstamp_t a);
    tstamp_t r;
    r = a;
    for (int i = 0; i < 4; i++) begin
      if (r.ns >= NS_PER_S) begin
        r.ns  = r.ns - NS_PER_S;
        r.sec = r.sec + 32'd1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tas_cfg_regs.sv
module tas_cfg_regs
  import tas_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int LW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          swap_take_i,
  output tstamp_t       base_o,
  output tstamp_t       cyc_o,
  output logic [31:0]   ext_o,
  output logic [LW-1:0] len_o,
  output logic          en_o,
  output logic          pend_o,
  output logic [7:0]    ofs_o
);
  tstamp_t base_q, cyc_raw_q, cyc_q;
  logic [31:0]   ext_q;
  logic [LW-1:0] len_q;
  logic          en_q, pend_q;
  logic [7:0]    ofs_q;
  logic          req_wr;
  logic          ctl_unused;

  assign req_wr     = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[1];
  assign ctl_unused = ^cfg_wdata[23:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      cyc_raw_q <= '0;
      cyc_q     <= '0;
      ext_q     <= '0;
      len_q     <= '0;
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      ofs_q     <= '0;
    end else begin
      cyc_q <= ts_norm(cyc_raw_q);
      if (cfg_we) begin
        case (cfg_addr)
          A_BASE_NS: base_q.ns     <= cfg_wdata;
          A_BASE_S:  base_q.sec    <= cfg_wdata;
          A_CYC_NS:  cyc_raw_q.ns  <= cfg_wdata;
          A_CYC_S:   cyc_raw_q.sec <= cfg_wdata;
          A_EXT:     ext_q <= (cfg_wdata >= NS_PER_S) ? (NS_PER_S - 32'd1) : cfg_wdata;
          A_LEN:     len_q <= (cfg_wdata > 32'(DEPTH)) ? LW'(DEPTH) : LW'(cfg_wdata);
          A_CTRL: begin
            en_q  <= cfg_wdata[0];
            ofs_q <= cfg_wdata[31:24];
          end
          default: ;
        endcase
      end
      if (req_wr)           pend_q <= 1'b1;
      else if (swap_take_i) pend_q <= 1'b0;
    end
  end

  assign base_o = base_q;
  assign cyc_o  = cyc_q;
  assign ext_o  = ext_q;
  assign len_o  = len_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign ofs_o  = ofs_q;

  p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (swap_take_i && !req_wr) |=> !pend_q);

  p_cyc_norm_r4: assert property (@(posedge clk) disable iff (rst)
    cyc_q.ns < NS_PER_S);
endmodule

// File: rtl/tas_list_mem.sv
module tas_list_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [0:2*DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[{rbank, raddr}];
  end
endmodule

// File: rtl/tas_sched_core.sv
module tas_sched_core
  import tas_pkg::*;
#(
  parameter int NQ = 8,
  parameter int AW = 10,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  tstamp_t       now_i,
  input  tstamp_t       base_i,
  input  tstamp_t       cyc_i,
  input  logic [31:0]   ext_i,
  input  logic [LW-1:0] len_i,
  input  logic          en_i,
  input  logic          pend_i,
  input  logic [7:0]    ofs_i,
  input  logic [31:0]   rdata_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_bank_o,
  output logic          act_bank_o,
  output logic          swap_take_o,
  output logic          swap_flag_o,
  output logic [NQ-1:0] gate_o
);
  sched_st_e     st_q, st_n;
  tstamp_t       nxt_q, nxt_n, est_q, est_n, eend_q, eend_n;
  tstamp_t       adj, bnd;
  logic [AW-1:0] idx_q, idx_n;
  logic          bank_q, bank_n, apply_q, apply_n, done_q, done_n;
  logic          flag_q, flag_n, take, hit, expire;
  logic [NQ-1:0] gate_q, gate_n;

  always_comb begin
    adj    = ts_add(now_i, ts_from_ns({24'd0, ofs_i}));
    bnd    = pend_i ? ts_add(nxt_q, ts_from_ns(ext_i)) : nxt_q;
    hit    = en_i && (st_q != ST_IDLE) && ts_ge(adj, bnd);
    expire = en_i && (st_q == ST_RUN) && !apply_q && !done_q && ts_ge(adj, eend_q);
    st_n    = st_q;
    nxt_n   = nxt_q;
    est_n   = est_q;
    eend_n  = eend_q;
    idx_n   = idx_q;
    bank_n  = bank_q;
    apply_n = apply_q;
    done_n  = done_q;
    gate_n  = gate_q;
    flag_n  = 1'b0;
    take    = 1'b0;
    if (!en_i) begin
      st_n    = ST_IDLE;
      gate_n  = '1;
      apply_n = 1'b0;
      done_n  = 1'b0;
    end else if (st_q == ST_IDLE) begin
      st_n   = ST_WAIT;
      nxt_n  = base_i;
      gate_n = '1;
    end else if (hit) begin
      st_n    = ST_RUN;
      nxt_n   = ts_add(bnd, cyc_i);
      est_n   = bnd;
      idx_n   = '0;
      apply_n = 1'b1;
      done_n  = 1'b0;
      if (pend_i) begin
        bank_n = ~bank_q;
        take   = 1'b1;
        flag_n = 1'b1;
      end
    end else if (apply_q) begin
      apply_n = 1'b0;
      if (len_i == '0) begin
        gate_n = '1;
        done_n = 1'b1;
      end else begin
        gate_n = rdata_i[24 +: NQ];
        eend_n = ts_add(est_q, ts_from_ns({8'd0, rdata_i[23:0]}));
      end
    end else if (expire) begin
      if (({1'b0, idx_q} + LW'(1)) < len_i) begin
        idx_n   = idx_q + AW'(1);
        est_n   = eend_q;
        apply_n = 1'b1;
      end else begin
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      nxt_q   <= '0;
      est_q   <= '0;
      eend_q  <= '0;
      idx_q   <= '0;
      bank_q  <= 1'b0;
      apply_q <= 1'b0;
      done_q  <= 1'b0;
      flag_q  <= 1'b0;
      gate_q  <= '1;
    end else begin
      st_q    <= st_n;
      nxt_q   <= nxt_n;
      est_q   <= est_n;
      eend_q  <= eend_n;
      idx_q   <= idx_n;
      bank_q  <= bank_n;
      apply_q <= apply_n;
      done_q  <= done_n;
      flag_q  <= flag_n;
      gate_q  <= gate_n;
    end
  end

  assign rd_addr_o   = idx_n;
  assign rd_bank_o   = bank_n;
  assign act_bank_o  = bank_q;
  assign swap_take_o = take;
  assign swap_flag_o = flag_q;
  assign gate_o      = gate_q;

  p_idle_open_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (gate_q == '1));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && apply_q && len_i != '0 && $stable(len_i)) |-> ({1'b0, idx_q} < len_i));

  p_hold_last_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i && st_q == ST_RUN && done_q && !hit) |=> $stable(gate_q));

  p_flag_after_req_r6: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> $past(pend_i));
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   tm_sec,
  input  logic [31:0]   tm_ns,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          lst_we,
  input  logic [AW-1:0] lst_addr,
  input  logic [31:0]   lst_wdata,
  output logic [NQ-1:0] gate_open,
  output logic          list_swapped
);
  tstamp_t       now, base, cyc;
  logic [31:0]   ext;
  logic [LW-1:0] len;
  logic          en, pend, take, act_bank, rd_bank;
  logic [7:0]    ofs;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rdata;

  assign now.sec = tm_sec;
  assign now.ns  = tm_ns;

  tas_cfg_regs #(.DEPTH(DEPTH), .LW(LW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .swap_take_i(take), .base_o(base), .cyc_o(cyc), .ext_o(ext), .len_o(len),
    .en_o(en), .pend_o(pend), .ofs_o(ofs)
  );

  tas_list_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(lst_we), .wbank(~act_bank), .waddr(lst_addr), .wdata(lst_wdata),
    .rbank(rd_bank), .raddr(rd_addr), .rdata(rdata)
  );

  tas_sched_core #(.NQ(NQ), .AW(AW), .LW(LW)) u_core (
    .clk(clk), .rst(rst), .now_i(now), .base_i(base), .cyc_i(cyc), .ext_i(ext),
    .len_i(len), .en_i(en), .pend_i(pend), .ofs_i(ofs), .rdata_i(rdata),
    .rd_addr_o(rd_addr), .rd_bank_o(rd_bank), .act_bank_o(act_bank),
    .swap_take_o(take), .swap_flag_o(list_swapped), .gate_o(gate_open)
  );
endmodule

// File: tb/tas_gate_sched_tb_top.sv
`timescale 1ns/1ps
module tas_gate_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tm_sec = '0, tm_ns = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lst_we = 1'b0;
  logic [9:0]  lst_addr = '0;
  logic [31:0] lst_wdata = '0;
  logic [7:0]  gate_open;
  logic        list_swapped;
  int checks = 0, failures = 0, swaps = 0;

  always #10 clk = ~clk;

  tas_gate_sched dut_i (
    .clk(clk), .rst(rst), .tm_sec(tm_sec), .tm_ns(tm_ns), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .lst_we(lst_we), .lst_addr(lst_addr),
    .lst_wdata(lst_wdata), .gate_open(gate_open), .list_swapped(list_swapped)
  );

  initial forever begin
    @(posedge clk);
    if (!rst && list_swapped) swaps++;
  end

  // Walk of list A (ptov 0): {time ns, expected gates, requirement}
  // rows 0: R1, rows 1-3: R2, rows 4-7: R3
  localparam logic [47:0] VEC [0:7] = '{
    {32'd900,  8'hFF, 8'd1}, {32'd1100, 8'h01, 8'd2}, {32'd1360, 8'h02, 8'd2},
    {32'd1560, 8'h04, 8'd2}, {32'd1800, 8'h04, 8'd3}, {32'd2100, 8'h01, 8'd3},
    {32'd2360, 8'h02, 8'd3}, {32'd2560, 8'h04, 8'd3}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at tm=%0d.%0d", req, got, exp, tm_sec, tm_ns);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_lst(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); lst_we = 1'b1; lst_addr = a; lst_wdata = d;
    @(negedge clk); lst_we = 1'b0;
  endtask

  task automatic run_to(input logic [31:0] t);
    while (tm_ns < t) begin
      @(negedge clk); tm_ns = tm_ns + 32'd20;
    end
  endtask

  task automatic jump(input logic [31:0] s, input logic [31:0] n);
    @(negedge clk); tm_sec = s; tm_ns = n;
    repeat (4) begin @(negedge clk); tm_ns = tm_ns + 32'd20; end
  endtask

  initial begin
    #(20.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset gates", 32'(gate_open), 32'hFF);
    chk("R1 reset flag", 32'(list_swapped), 32'h0);
    // list A into shadow bank; switch at the base time
    wr_lst(10'd0, {8'h01, 24'd200});
    wr_lst(10'd1, {8'h02, 24'd300});
    wr_lst(10'd2, {8'h04, 24'd100});
    wr_cfg(3'd0, 32'd1000);
    wr_cfg(3'd1, 32'd0);
    wr_cfg(3'd2, 32'd1000);
    wr_cfg(3'd3, 32'd0);
    wr_cfg(3'd4, 32'd0);
    wr_cfg(3'd5, 32'd3);
    wr_cfg(3'd6, 32'h0000_0003);
    for (int i = 0; i < 8; i++) begin
      run_to(VEC[i][47:16]);
      chk($sformatf("R%0d table row %0d", VEC[i][7:0], i), 32'(gate_open), 32'(VEC[i][15:8]));
    end
    // R8: offset of 100 ns makes the 3000 boundary fire at 2900
    wr_cfg(3'd6, 32'h6400_0001);
    run_to(32'd2980);
    chk("R8 early boundary", 32'(gate_open), 32'h01);
    run_to(32'd3300);
    chk("R8 entry1", 32'(gate_open), 32'h02);
    // R5: list B goes to shadow, active gates unaffected
    wr_lst(10'd0, {8'h10, 24'd400});
    wr_lst(10'd1, {8'h20, 24'd300});
    wr_lst(10'd2, {8'h40, 24'd100});
    run_to(32'd3460);
    chk("R5 shadow write no effect", 32'(gate_open), 32'h04);
    // R7: extension 200 delays the switching boundary to 4100 real
    wr_cfg(3'd4, 32'd200);
    wr_cfg(3'd6, 32'h6400_0003);
    run_to(32'd3960);
    chk("R7 switch delayed", 32'(gate_open), 32'h04);
    run_to(32'd4180);
    chk("R6 new list entry0", 32'(gate_open), 32'h10);
    chk("R6 one flag per swap", 32'(swaps), 32'd2);
    run_to(32'd4640);
    chk("R2 list B entry1", 32'(gate_open), 32'h20);
    run_to(32'd4860);
    chk("R2 list B entry2", 32'(gate_open), 32'h40);
    run_to(32'd4960);
    chk("R3 hold last", 32'(gate_open), 32'h40);
    run_to(32'd5160);
    chk("R6 request cleared, no extension", 32'(gate_open), 32'h10);
    // R9: disable opens all gates
    wr_cfg(3'd6, 32'h0000_0000);
    @(negedge clk);
    chk("R9 disable opens", 32'(gate_open), 32'hFF);
    // R10: length 0 keeps gates open while running
    wr_cfg(3'd5, 32'd0);
    wr_cfg(3'd0, 32'd6000);
    wr_cfg(3'd6, 32'h0000_0001);
    run_to(32'd6100);
    chk("R10 len 0 open", 32'(gate_open), 32'hFF);
    // R4: cycle 2,000,000,500 ns acts as 2 s + 500 ns
    wr_cfg(3'd6, 32'h0000_0000);
    wr_cfg(3'd5, 32'd2);
    wr_cfg(3'd0, 32'd0);
    wr_cfg(3'd1, 32'd10);
    wr_cfg(3'd2, 32'd2000000500);
    wr_cfg(3'd3, 32'd0);
    wr_cfg(3'd4, 32'd0);
    @(negedge clk); tm_sec = 32'd9; tm_ns = 32'd0;
    wr_cfg(3'd6, 32'h0000_0001);
    jump(32'd10, 32'd0);
    chk("R4 first entry", 32'(gate_open), 32'h10);
    jump(32'd10, 32'd720);
    chk("R4 hold entry1", 32'(gate_open), 32'h20);
    jump(32'd12, 32'd100);
    chk("R4 no boundary before 12s500", 32'(gate_open), 32'h20);
    jump(32'd12, 32'd520);
    chk("R4 boundary at 12s500", 32'(gate_open), 32'h10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule